// File: doc/BRIEF.md
# Retimer Channel Output Source Selector

This block is the control logic for one channel of a serial retimer. It decides what drives the channel's output driver. The candidates are raw equalized data, retimed data, the in-phase or quadrature VCO clock, the PRBS generator stream, and a free-running slow test clock. The output can also be muted. The analog sources are modelled as single-bit inputs. The block also drives the channel power-down and mute controls.

The choice follows the signal-detect and CDR-lock status unless a register override takes over. A small register bank, written through a simple address/data write port, holds these controls:
- the override enable;
- a 3-bit source selection code;
- a pair of bits that can force signal detect on;
- enables that gate the quadrature clock, the PRBS stream and raw mode.

All control outputs are registered. A change in status or in a register reaches the outputs one clock later.

Top module: `retimer_out_sel`

## Requirements
- R1: During and after reset, with no signal detected, the outputs are src_o = 0 (mute), drv_mute_o = 1, pwr_dn_o = 1, sd_eff_o = 0 and drv_data_o = 0. The selection code resets to 7 and every other register bit resets to 0.
- R2: src_o reports the active source as 0 mute, 1 raw, 2 retimed, 3 in-phase clock, 4 quadrature clock, 5 PRBS, 6 test clock. drv_data_o carries the matching data input, or 0 when src_o is 0. drv_mute_o is 1 exactly when src_o is 0.
- R3: With override clear, an effective signal and the CDR locked, the source is retimed data (src_o = 2).
- R4: With override clear, an effective signal and the CDR unlocked, the source follows the selection code (sel register, address 3, bits 2:0). The reset code 7 gives mute, and code 0 gives raw data.
- R5: With override set (ctrl register, address 1, bit 0), the source follows the selection code whatever the lock state. The code map is 0 raw, 1 retimed, 2 in-phase, 3 quadrature, 4 PRBS, 5 test clock, 7 mute.
- R6: The effective signal detect is forced to 1 when the force register (address 2) holds bit 1 = 1 and bit 0 = 0. Any other value of those two bits leaves it equal to sig_det_i.
- R7: With no effective signal, pwr_dn_o = 1 and the output is muted, regardless of the override, the selection code or the lock state.
- R8: Code 3 gives the quadrature clock only when ctrl bit 1 and sel bit 4 are both 1. Otherwise it gives mute.
- R9: Code 4 gives PRBS only when ctrl bit 2 (generator enable) is 1. Code 0 gives raw data only when ctrl bit 3 (re-search disable) is 1. Otherwise each gives mute.
- R10: Code 6 (invalid) gives mute, and src_o never reports 7.
- R11: A register write or a status change before clock edge k shows on the control outputs after edge k+1 for a write, and after edge k for a status change.
- R12: sd_eff_o reports the effective signal detect, and pwr_dn_o is always its inverse.
- R13: Writes to addresses other than 1, 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| sig_det_i | input | 1 | Hardware signal detect |
| cdr_lock_i | input | 1 | CDR lock status |
| raw_data_i | input | 1 | Raw equalized data |
| retimed_data_i | input | 1 | Retimed data |
| vco_i_clk_i | input | 1 | VCO in-phase clock |
| vco_q_clk_i | input | 1 | VCO quadrature clock |
| prbs_data_i | input | 1 | PRBS generator output |
| test_clk_i | input | 1 | Free-running slow test clock |
| drv_data_o | output | 1 | Output driver data |
| drv_mute_o | output | 1 | Output driver mute |
| pwr_dn_o | output | 1 | Channel power-down |
| sd_eff_o | output | 1 | Effective signal detect |
| src_o | output | 3 | Active source code |

## Verification
The selector is driven with the detector off and then on, with lock toggled under both override settings. This separates the status-driven path from the override path. Every selection code is swept with its gating enables both clear and set, which separates gated codes from ungated ones and exposes code 6. The four force-bit patterns are applied with the detector off, so only the forced-on pattern can lift power-down. Writes to unmapped addresses, followed by status changes, show that no hidden state moved. The data inputs toggle in distinct patterns, so a wrong multiplexer leg shows on drv_data_o.

// File: rtl/rtsel_pkg.sv
package rtsel_pkg;
  typedef enum logic [2:0] {
    SRC_MUTE    = 3'd0,
    SRC_RAW     = 3'd1,
    SRC_RETIMED = 3'd2,
    SRC_ICLK    = 3'd3,
    SRC_QCLK    = 3'd4,
    SRC_PRBS    = 3'd5,
    SRC_TCLK    = 3'd6
  } src_e;

  localparam int unsigned NUM_SRC = 7;
  localparam int unsigned SEL_W   = 3;

  localparam logic [SEL_W-1:0] SEL_RAW  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_RTM  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_ICLK = 3'd2;
  localparam logic [SEL_W-1:0] SEL_QCLK = 3'd3;
  localparam logic [SEL_W-1:0] SEL_PRBS = 3'd4;
  localparam logic [SEL_W-1:0] SEL_TCLK = 3'd5;
  localparam logic [SEL_W-1:0] SEL_MUTE = 3'd7;

  typedef struct packed {
    logic             ovr;
    logic             q_en_a;
    logic             prbs_en;
    logic             raw_keep;
    logic             force_on;
    logic             force_off;
    logic             q_en_b;
    logic [SEL_W-1:0] sel;
  } cfg_t;
endpackage

// File: rtl/rtsel_regs.sv
module rtsel_regs
  import rtsel_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'd1,
  parameter logic [ADDR_W-1:0] SD_ADDR   = 4'd2,
  parameter logic [ADDR_W-1:0] SEL_ADDR  = 4'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output cfg_t              cfg_o
);
  localparam int unsigned USED_W = 5;

  cfg_t cfg_q;
  logic unused_bits;
  assign unused_bits = ^wr_data_i[DATA_W-1:USED_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      cfg_q.sel <= SEL_MUTE;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        CTRL_ADDR: begin
          cfg_q.ovr      <= wr_data_i[0];
          cfg_q.q_en_a   <= wr_data_i[1];
          cfg_q.prbs_en  <= wr_data_i[2];
          cfg_q.raw_keep <= wr_data_i[3];
        end
        SD_ADDR: begin
          cfg_q.force_off <= wr_data_i[0];
          cfg_q.force_on  <= wr_data_i[1];
        end
        SEL_ADDR: begin
          cfg_q.sel    <= wr_data_i[SEL_W-1:0];
          cfg_q.q_en_b <= wr_data_i[4];
        end
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/rtsel_decode.sv
module rtsel_decode
  import rtsel_pkg::*;
(
  input  cfg_t cfg_i,
  input  logic sig_det_i,
  input  logic cdr_lock_i,
  output src_e src_o,
  output logic sd_eff_o
);
  src_e code_src;

  always_comb begin
    unique case (cfg_i.sel)
      SEL_RAW:  code_src = cfg_i.raw_keep ? SRC_RAW : SRC_MUTE;
      SEL_RTM:  code_src = SRC_RETIMED;
      SEL_ICLK: code_src = SRC_ICLK;
      SEL_QCLK: code_src = (cfg_i.q_en_a && cfg_i.q_en_b) ? SRC_QCLK : SRC_MUTE;
      SEL_PRBS: code_src = cfg_i.prbs_en ? SRC_PRBS : SRC_MUTE;
      SEL_TCLK: code_src = SRC_TCLK;
      default:  code_src = SRC_MUTE;
    endcase
  end

  assign sd_eff_o = (cfg_i.force_on && !cfg_i.force_off) || sig_det_i;

  always_comb begin
    if (!sd_eff_o)                     src_o = SRC_MUTE;
    else if (!cfg_i.ovr && cdr_lock_i) src_o = SRC_RETIMED;
    else                               src_o = code_src;
  end
endmodule

// File: rtl/rtsel_mux.sv
module rtsel_mux
  import rtsel_pkg::*;
(
  input  src_e               src_i,
  input  logic [NUM_SRC-1:0] srcs_i,
  output logic               data_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_leg
    if (g == 0) begin : g_mute
      assign hit[g] = 1'b0;
    end else begin : g_src
      assign hit[g] = (src_i == src_e'(g)) & srcs_i[g];
    end
  end

  assign data_o = |hit;
endmodule

// File: rtl/retimer_out_sel.sv
module retimer_out_sel
  import rtsel_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sig_det_i,
  input  logic              cdr_lock_i,
  input  logic              raw_data_i,
  input  logic              retimed_data_i,
  input  logic              vco_i_clk_i,
  input  logic              vco_q_clk_i,
  input  logic              prbs_data_i,
  input  logic              test_clk_i,
  output logic              drv_data_o,
  output logic              drv_mute_o,
  output logic              pwr_dn_o,
  output logic              sd_eff_o,
  output logic [2:0]        src_o
);
  cfg_t cfg;
  src_e src_d, src_q;
  logic sd_eff_d, sd_eff_q, mute_q, pwr_q;
  logic [NUM_SRC-1:0] srcs;

  rtsel_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .cfg_o(cfg)
  );

  rtsel_decode u_dec (
    .cfg_i(cfg), .sig_det_i, .cdr_lock_i, .src_o(src_d), .sd_eff_o(sd_eff_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= SRC_MUTE;
      sd_eff_q <= 1'b0;
      mute_q   <= 1'b1;
      pwr_q    <= 1'b1;
    end else begin
      src_q    <= src_d;
      sd_eff_q <= sd_eff_d;
      mute_q   <= (src_d == SRC_MUTE);
      pwr_q    <= !sd_eff_d;
    end
  end

  assign srcs = {test_clk_i, prbs_data_i, vco_q_clk_i, vco_i_clk_i,
                 retimed_data_i, raw_data_i, 1'b0};

  rtsel_mux u_mux (.src_i(src_q), .srcs_i(srcs), .data_o(drv_data_o));

  assign drv_mute_o = mute_q;
  assign pwr_dn_o   = pwr_q;
  assign sd_eff_o   = sd_eff_q;
  assign src_o      = src_q;
endmodule

// File: rtl/rtsel_chk.sv
module rtsel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sig_det_i,
  input logic       cdr_lock_i,
  input logic       drv_data_o,
  input logic       drv_mute_o,
  input logic       pwr_dn_o,
  input logic       sd_eff_o,
  input logic [2:0] src_o,
  input logic       ovr_q,
  input logic [2:0] sel_q
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_pwrdn_mutes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_o |-> (drv_mute_o && !drv_data_o));

  p_mute_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_mute_o |-> (!drv_data_o && src_o == 3'd0));

  p_no_invalid_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_o != 3'd7);

  p_sdeff_pwr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_eff_o != pwr_dn_o);

  p_detect_passes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(sig_det_i)) |-> sd_eff_o);

  p_lock_retimed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(sig_det_i && cdr_lock_i && !ovr_q)) |-> (src_o == 3'd2));

  p_ovr_mute_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(ovr_q && sel_q == 3'd7)) |-> drv_mute_o);
endmodule

bind retimer_out_sel rtsel_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sig_det_i(sig_det_i), .cdr_lock_i(cdr_lock_i),
  .drv_data_o(drv_data_o), .drv_mute_o(drv_mute_o), .pwr_dn_o(pwr_dn_o),
  .sd_eff_o(sd_eff_o), .src_o(src_o), .ovr_q(cfg.ovr), .sel_q(cfg.sel)
);

// File: tb/test_retimer_out_sel.sv
module test_retimer_out_sel;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic sd = 1'b0, lock = 1'b0;
  logic raw_d = 0, rtm_d = 0, iclk = 0, qclk = 0, prbs = 0, tclk = 0;
  logic drv_data, drv_mute, pwr_dn, sd_eff;
  logic [2:0] src;

  int checks = 0, failures = 0, cyc = 0;
  bit cmp_on = 0, done = 0;
  string cur_req = "R1";

  // behavioural model state
  bit m_ovr, m_qa, m_prbs, m_rawk, m_fon, m_foff, m_qb;
  int m_sel = 7;
  int exp_src = 0;
  bit exp_sd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  retimer_out_sel i_retimer_out_sel (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .sig_det_i(sd), .cdr_lock_i(lock),
    .raw_data_i(raw_d), .retimed_data_i(rtm_d), .vco_i_clk_i(iclk),
    .vco_q_clk_i(qclk), .prbs_data_i(prbs), .test_clk_i(tclk),
    .drv_data_o(drv_data), .drv_mute_o(drv_mute), .pwr_dn_o(pwr_dn),
    .sd_eff_o(sd_eff), .src_o(src)
  );

  function automatic int model_src(bit s, bit l);
    bit e = (m_fon && !m_foff) || s;
    if (!e) return 0;
    if (!m_ovr && l) return 2;
    case (m_sel)
      0: return m_rawk ? 1 : 0;
      1: return 2;
      2: return 3;
      3: return (m_qa && m_qb) ? 4 : 0;
      4: return m_prbs ? 5 : 0;
      5: return 6;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ovr = 0; m_qa = 0; m_prbs = 0; m_rawk = 0; m_fon = 0; m_foff = 0; m_qb = 0;
      m_sel = 7; exp_src = 0; exp_sd = 0;
    end else begin
      exp_src = model_src(sd, lock);
      exp_sd  = (m_fon && !m_foff) || sd;
      if (wr_en) begin
        case (wr_addr)
          4'd1: begin m_ovr = wr_data[0]; m_qa = wr_data[1]; m_prbs = wr_data[2]; m_rawk = wr_data[3]; end
          4'd2: begin m_foff = wr_data[0]; m_fon = wr_data[1]; end
          4'd3: begin m_sel = int'(wr_data[2:0]); m_qb = wr_data[4]; end
          default: ;
        endcase
      end
    end
  end

  function automatic bit exp_data(int s);
    case (s)
      1: return raw_d;
      2: return rtm_d;
      3: return iclk;
      4: return qclk;
      5: return prbs;
      6: return tclk;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, then move the data inputs
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(cur_req, "src_o", int'(src), exp_src);
      chk(cur_req, "drv_mute_o", int'(drv_mute), int'(exp_src == 0));
      chk("R12", "sd_eff_o", int'(sd_eff), int'(exp_sd));
      chk("R12", "pwr_dn_o", int'(pwr_dn), int'(!exp_sd));
      chk("R2", "drv_data_o", int'(drv_data), int'(exp_data(exp_src)));
    end
    cyc++;
    raw_d = cyc[0]; rtm_d = cyc[1] ^ cyc[0]; iclk = cyc[2]; qclk = ~cyc[0];
    prbs = cyc[3] ^ cyc[1]; tclk = cyc[4];
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(2);
    cur_req = "R1";
    chk("R1", "reset src_o", int'(src), 0);
    chk("R1", "reset drv_mute_o", int'(drv_mute), 1);
    chk("R1", "reset pwr_dn_o", int'(pwr_dn), 1);
    chk("R1", "reset sd_eff_o", int'(sd_eff), 0);
    chk("R1", "reset drv_data_o", int'(drv_data), 0);
    rst_n = 1'b1;
    cmp_on = 1;
    tick(3);

    // R7: no signal, override and lock do not matter
    cur_req = "R7";
    wr(1, 'h0F); wr(3, 'h11); lock = 1; tick(4);
    wr(3, 'h02); tick(3);
    wr(1, 'h00); wr(3, 'h07); lock = 0; tick(3);

    // R3: status-driven retimed
    cur_req = "R3";
    sd = 1; lock = 1; tick(4);

    // R11: one-cycle latency on status change
    cur_req = "R11";
    lock = 0; @(negedge clk);
    chk("R11", "mute one cycle after unlock", int'(src), 0);
    lock = 1; @(negedge clk);
    chk("R11", "retimed one cycle after lock", int'(src), 2);
    wr(3, 'h01); lock = 0;
    chk("R11", "code 1 unlocked after write", int'(src), 2);

    // R4: unlocked follows code
    cur_req = "R4";
    wr(3, 'h07); tick(3);
    wr(3, 'h00); tick(3);
    cur_req = "R9";
    wr(1, 'h08); tick(3);
    cur_req = "R4";
    lock = 1; tick(3); lock = 0; tick(2);

    // R5/R8/R9/R10: override sweep over codes, enables and lock
    cur_req = "R5";
    for (int en = 0; en < 2; en++) begin
      for (int c = 0; c < 8; c++) begin
        for (int l = 0; l < 2; l++) begin
          cur_req = (c == 3) ? "R8" : (c == 4 || c == 0) ? "R9" : (c == 6) ? "R10" : "R5";
          lock = l[0];
          wr(1, en ? 'h0F : 'h01);
          wr(3, c | (en ? 'h10 : 'h00));
          tick(3);
        end
      end
    end
    cur_req = "R8";
    wr(1, 'h03); wr(3, 'h03); tick(3);
    wr(1, 'h01); wr(3, 'h13); tick(3);
    wr(1, 'h03); wr(3, 'h13); tick(3);

    // R6: force patterns with detector off
    cur_req = "R6";
    sd = 0; wr(3, 'h05);
    for (int f = 0; f < 4; f++) begin
      wr(2, f); tick(3);
    end
    wr(2, 'h02); tick(2);
    chk("R6", "forced detect", int'(sd_eff), 1);
    wr(2, 'h00); tick(2);
    chk("R6", "force released", int'(sd_eff), 0);

    // R13: unmapped writes change nothing
    cur_req = "R13";
    sd = 1; lock = 0; wr(1, 'h0F); wr(3, 'h15); tick(2);
    wr(0, 'hFF); wr(4, 'h00); wr(15, 'hFF); wr(7, 'h00); tick(3);
    chk("R13", "src after unmapped writes", int'(src), 6);
    lock = 1; tick(2); sd = 0; tick(2); sd = 1; tick(3);

    tick(2);
    finish_run();
  end
endmodule